// File: doc/BRIEF.md
# NAND Flash Target Command Interpreter

This block stands on the device side of an 8-bit NAND flash bus. It decodes command, address and data bytes, and it models a small memory array. The array has a configurable page size, pages per block and block count. A page read copies the selected page into an internal page buffer. The host then reads that buffer out byte by byte.

The buffer also serves two other operations. A normal program loads bytes into it before they are written. A copy-back writes the buffer back into a different page with no data transfer on the bus. The array is split into two planes by the lowest block-address bit, and copy-back is allowed only within one plane. A page written by copy-back refuses further programming until its block is erased.

Erase takes a setup command, a block address and a separate confirm command. Each operation holds the ready line low for a parameterised number of cycles. A status command returns a byte that carries the pass/fail result of the last program or erase. The block is meant as a synthesizable target for exercising a flash sequencer.

Top module: `nand_target`

## Requirements
- R1: After reset, ready is high, every array byte reads FFh, and a status read returns C0h.
- R2: A byte is latched on the cycle that wr_n rises. It is a command when cmd_lat=1 and adr_lat=0, an address when adr_lat=1 and cmd_lat=0, and data when both are 0. Command 00h is followed by three address bytes: the column, then row bits 7:0, then row bits 15:8. The row's low log2(PAGES_PER_BLK) bits select the page within the block, and the bits above them select the block. The addressed page is loaded into the buffer, and ready stays low for T_READ cycles. Each rising edge of rd_n then advances the output byte, starting at the given column.
- R3: Command 80h sets the buffer to all FFh. It takes three address bytes, then data bytes stored from the given column onward. Command 10h then ANDs the buffer into the page, leaving bytes that were not loaded unchanged, and holds ready low for T_PROG cycles.
- R4: Command 8Ah with three address bytes ANDs the buffer into the destination page with no data input. It holds ready low for T_PROG cycles and clears the fail flag.
- R5: A copy-back fails, with status bit 0 set and the destination left unchanged, if the destination plane bit (the lowest block bit) differs from that of the last page read.
- R6: A page written by copy-back fails any later program or copy-back, with status bit 0 set and data unchanged, until its block is erased.
- R7: Command 60h, two address bytes (row bits 7:0, then 15:8) and then D0h erase the whole addressed block to FFh. The page bits of that address are ignored. The erase clears the block's copy-back marks and holds ready low for T_ERASE cycles.
- R8: D0h with no pending erase setup starts nothing. Any other command that arrives after the setup cancels it and is decoded normally.
- R9: Command 70h switches the output to the status byte, in both the ready and the busy state. Bit 7 is 1, bit 6 is ready, bit 0 is the last program/erase fail flag, and the other bits are 0.
- R10: While ready is low, every command other than 70h is ignored, and so are all address bytes, data bytes and rd_n edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lat | input | 1 | Marks the bus byte as a command |
| adr_lat | input | 1 | Marks the bus byte as an address |
| wr_n | input | 1 | Write strobe; the byte is taken on its rising edge |
| rd_n | input | 1 | Read strobe; its rising edge advances the output byte |
| bus_in | input | 8 | Command, address or data byte from the host |
| bus_out | output | 8 | Buffer byte, or the status byte after 70h |
| ready | output | 1 | High when idle, low while an operation runs |

## Verification
The read path is tried from column 0 and from a middle column, on both an erased page and a programmed page. This shows that the column start and the pointer advance are honoured. Programs are tried on an erased page and again on the same page, which separates AND-merging from overwriting.

Copy-back is tried to a same-plane destination and to one in the other plane, and then a normal program is aimed at the copied page. The pass, the fail and the unchanged data tell the plane rule apart from the copied-page rule.

Erase is tried in three ways: started cleanly, cancelled by a status command, and issued while another operation is busy. Reading data back afterwards shows that only the confirmed, idle-time erase touches the array.

// File: rtl/nand_target.sv
module nand_target #(
  parameter int PAGE_BYTES    = 16,
  parameter int PAGES_PER_BLK = 4,
  parameter int BLOCKS        = 4,
  parameter int T_READ        = 8,
  parameter int T_PROG        = 12,
  parameter int T_ERASE       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_lat,
  input  logic       adr_lat,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       ready
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = $clog2(PAGES_PER_BLK);
  localparam int BLK_W  = $clog2(BLOCKS);
  localparam int ROW_W  = PG_W + BLK_W;
  localparam int NPAGES = PAGES_PER_BLK * BLOCKS;
  localparam int MEM_N  = NPAGES * PAGE_BYTES;
  localparam int MEM_W  = ROW_W + COL_W;
  localparam int TMAX   = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                             : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CNT_W  = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RADR, S_CADR, S_PADR, S_PDAT, S_EADR, S_EWAIT} mode_t;

  mode_t             mode;
  logic              we_q, re_q, stat, fail, src_ok, src_pl;
  logic [1:0]        acnt;
  logic [7:0]        a_lo;
  logic [COL_W-1:0]  ptr;
  logic [ROW_W-1:0]  pg_sel;
  logic [BLK_W-1:0]  er_blk;
  logic [CNT_W-1:0]  cnt;
  logic [NPAGES-1:0] copied;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic [7:0]        mem  [MEM_N];

  wire we_rise = wr_n & ~we_q;
  wire re_rise = rd_n & ~re_q;
  wire cmd_wr  = we_rise & cmd_lat & ~adr_lat;
  wire adr_wr  = we_rise & adr_lat & ~cmd_lat;
  wire dat_wr  = we_rise & ~adr_lat & ~cmd_lat;
  wire rdy     = (cnt == '0);

  wire [15:0]      row16 = {bus_in, a_lo};
  wire [ROW_W-1:0] row   = ROW_W'(row16 % NPAGES);
  wire             plane = row[PG_W];

  assign ready   = rdy;
  assign bus_out = stat ? {1'b1, rdy, 5'b0, fail} : pbuf[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= S_IDLE;
      we_q   <= 1'b1;
      re_q   <= 1'b1;
      stat   <= 1'b0;
      fail   <= 1'b0;
      src_ok <= 1'b0;
      src_pl <= 1'b0;
      acnt   <= '0;
      a_lo   <= '0;
      ptr    <= '0;
      pg_sel <= '0;
      er_blk <= '0;
      cnt    <= '0;
      copied <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[COL_W'(i)] <= 8'hFF;
      for (int k = 0; k < MEM_N; k++) mem[MEM_W'(k)] <= 8'hFF;
    end else begin
      we_q <= wr_n;
      re_q <= rd_n;
      if (!rdy) cnt <= cnt - 1'b1;

      if (cmd_wr && (rdy || bus_in == 8'h70)) begin
        acnt <= '0;
        mode <= S_IDLE;
        stat <= 1'b0;
        case (bus_in)
          8'h00: mode <= S_RADR;
          8'h8A: mode <= S_CADR;
          8'h80: begin
            mode <= S_PADR;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[COL_W'(i)] <= 8'hFF;
          end
          8'h10: if (mode == S_PDAT) begin
            cnt <= CNT_W'(T_PROG);
            if (copied[pg_sel]) fail <= 1'b1;
            else begin
              fail <= 1'b0;
              for (int i = 0; i < PAGE_BYTES; i++)
                mem[{pg_sel, COL_W'(i)}] <= mem[{pg_sel, COL_W'(i)}] & pbuf[COL_W'(i)];
            end
          end
          8'h60: mode <= S_EADR;
          8'hD0: if (mode == S_EWAIT) begin
            cnt  <= CNT_W'(T_ERASE);
            fail <= 1'b0;
            for (int p = 0; p < PAGES_PER_BLK; p++) begin
              copied[{er_blk, PG_W'(p)}] <= 1'b0;
              for (int i = 0; i < PAGE_BYTES; i++)
                mem[{er_blk, PG_W'(p), COL_W'(i)}] <= 8'hFF;
            end
          end
          8'h70: stat <= 1'b1;
          default: ;
        endcase
      end else if (adr_wr && rdy) begin
        if (mode == S_EADR) begin
          if (acnt == 2'd0) begin
            a_lo <= bus_in;
            acnt <= 2'd1;
          end else begin
            er_blk <= row[ROW_W-1:PG_W];
            mode   <= S_EWAIT;
          end
        end else if (mode == S_RADR || mode == S_CADR || mode == S_PADR) begin
          if (acnt == 2'd0) begin
            ptr  <= bus_in[COL_W-1:0];
            acnt <= 2'd1;
          end else if (acnt == 2'd1) begin
            a_lo <= bus_in;
            acnt <= 2'd2;
          end else begin
            pg_sel <= row;
            mode   <= (mode == S_PADR) ? S_PDAT : S_IDLE;
            if (mode == S_RADR) begin
              cnt    <= CNT_W'(T_READ);
              src_ok <= 1'b1;
              src_pl <= plane;
              for (int i = 0; i < PAGE_BYTES; i++) pbuf[COL_W'(i)] <= mem[{row, COL_W'(i)}];
            end else if (mode == S_CADR) begin
              cnt <= CNT_W'(T_PROG);
              if (!src_ok || plane != src_pl || copied[row]) fail <= 1'b1;
              else begin
                fail        <= 1'b0;
                copied[row] <= 1'b1;
                for (int i = 0; i < PAGE_BYTES; i++)
                  mem[{row, COL_W'(i)}] <= mem[{row, COL_W'(i)}] & pbuf[COL_W'(i)];
              end
            end
          end
        end
      end else if (dat_wr && rdy && mode == S_PDAT) begin
        pbuf[ptr] <= bus_in;
        ptr       <= ptr + 1'b1;
      end else if (re_rise && rdy && !stat) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R2
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && rdy && mode == S_RADR && acnt == 2'd2) |=> !ready);

  // R5
  plane_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && rdy && mode == S_CADR && acnt == 2'd2 && src_ok && plane != src_pl) |=> (fail && !ready));

  // R6
  copied_prog_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rdy && bus_in == 8'h10 && mode == S_PDAT && copied[pg_sel]) |=> fail);

  // R8
  no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rdy && bus_in == 8'hD0 && mode != S_EWAIT) |=> ready);

  // R10
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> mode == S_IDLE);
endmodule

// File: tb/nand_target_bench.sv
module nand_target_bench;
  localparam int TR = 8, TP = 12, TE = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_lat = 1'b0, adr_lat = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic ready;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp;

  always #5 clk = ~clk;

  nand_target #(.PAGE_BYTES(16), .PAGES_PER_BLK(4), .BLOCKS(4),
                .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) u_nand_target (
    .clk(clk), .rst_n(rst_n), .cmd_lat(cmd_lat), .adr_lat(adr_lat), .wr_n(wr_n),
    .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out), .ready(ready));

  initial forever begin
    logic [7:0] e;
    string t;
    @(smp);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_cmp++;
    if (bus_out !== e) begin
      n_bad++;
      $display("FAIL %s: bus_out=%02h expected %02h", t, bus_out, e);
    end
  end

  task automatic chk(string t, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic put(logic c, logic a, logic [7:0] b);
    @(negedge clk);
    cmd_lat = c; adr_lat = a; bus_in = b; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cmd_lat = 1'b0; adr_lat = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b); put(1'b1, 1'b0, b); endtask
  task automatic adr(logic [7:0] b); put(1'b0, 1'b1, b); endtask
  task automatic dat(logic [7:0] b); put(1'b0, 1'b0, b); endtask

  task automatic rd_exp(logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> smp;
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_page(logic [7:0] row, logic [7:0] col);
    int n;
    cmd(8'h00); adr(col); adr(row); adr(8'h00);
    wait_rdy(n);
  endtask

  task automatic status(logic [7:0] e, string t);
    cmd(8'h70);
    rd_exp(e, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    status(8'hC0, "R1 reset status");

    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h00);
    wait_rdy(n);
    chk("R2 read busy cycles", n, TR);
    rd_exp(8'hFF, "R2 erased byte 0");
    rd_exp(8'hFF, "R2 erased byte 1");

    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00);
    dat(8'hA5); dat(8'h3C); dat(8'h0F); dat(8'hF0);
    cmd(8'h10);
    wait_rdy(n);
    chk("R3 program busy cycles", n, TP);
    status(8'hC0, "R3 program pass");
    rd_page(8'h01, 8'h02);
    rd_exp(8'h0F, "R2 column start");
    rd_exp(8'hF0, "R2 column advance");
    rd_exp(8'hFF, "R3 unloaded byte kept");

    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00); dat(8'h0F); cmd(8'h10);
    wait_rdy(n);
    rd_page(8'h01, 8'h00);
    rd_exp(8'h05, "R3 AND merge");
    rd_exp(8'h3C, "R3 untouched byte");

    rd_page(8'h01, 8'h00);
    cmd(8'h8A); adr(8'h00); adr(8'h09); adr(8'h00);
    wait_rdy(n);
    chk("R4 copy-back busy cycles", n, TP);
    status(8'hC0, "R4 copy-back pass");
    rd_page(8'h09, 8'h00);
    rd_exp(8'h05, "R4 copied byte 0");
    rd_exp(8'h3C, "R4 copied byte 1");
    rd_exp(8'h0F, "R4 copied byte 2");
    rd_exp(8'hF0, "R4 copied byte 3");
    rd_exp(8'hFF, "R4 copied byte 4");

    rd_page(8'h01, 8'h00);
    cmd(8'h8A); adr(8'h00); adr(8'h05); adr(8'h00);
    wait_rdy(n);
    status(8'hC1, "R5 cross-plane fail");
    rd_page(8'h05, 8'h00);
    rd_exp(8'hFF, "R5 destination unchanged");

    cmd(8'h80); adr(8'h00); adr(8'h09); adr(8'h00); dat(8'h00); cmd(8'h10);
    wait_rdy(n);
    status(8'hC1, "R6 program of copied page fails");
    rd_page(8'h09, 8'h00);
    rd_exp(8'h05, "R6 copied page data kept");

    cmd(8'h60); adr(8'h09); adr(8'h00);
    status(8'hC1, "R8 status decoded after setup");
    cmd(8'hD0);
    chk("R8 no erase without setup", ready, 1);
    rd_page(8'h09, 8'h00);
    rd_exp(8'h05, "R8 data survives cancelled erase");

    cmd(8'h60); adr(8'h09); adr(8'h00); cmd(8'hD0);
    wait_rdy(n);
    chk("R7 erase busy cycles", n, TE);
    status(8'hC0, "R7 erase pass");
    rd_page(8'h09, 8'h00);
    rd_exp(8'hFF, "R7 erased page byte");
    rd_page(8'h01, 8'h00);
    rd_exp(8'h05, "R7 other block kept");
    cmd(8'h80); adr(8'h00); adr(8'h09); adr(8'h00); dat(8'h11); cmd(8'h10);
    wait_rdy(n);
    status(8'hC0, "R6 mark cleared by erase");
    rd_page(8'h09, 8'h00);
    rd_exp(8'h11, "R6 reprogram after erase");

    cmd(8'h60); adr(8'h0C); adr(8'h00); cmd(8'hD0);
    cmd(8'h70);
    rd_exp(8'h80, "R9 status while busy");
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    wait_rdy(n);
    rd_exp(8'hC0, "R10 status after busy");
    rd_page(8'h01, 8'h00);
    rd_exp(8'h05, "R10 erase during busy ignored");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule